// File: doc/BRIEF.md
# Priority Interrupt Controller with Pending Register

This block gathers fifteen level-high interrupt request lines, numbered 1 to 15, into a sticky pending register. Each line has an enable (mask) bit and a priority-level bit. The block always presents to a single processor the number of the most urgent pending line that is enabled. The processor returns a one-cycle acknowledge that carries the number it is servicing, and that number's pending bit is cleared. A request number of 0 means that nothing is being requested.

Software reaches the controller through an APB-style slave port with no wait states. Through this port it reads and writes the level and mask registers, reads the pending register, and sets or clears pending bits through write-one-to-set and write-one-to-clear locations. Every register holds line n in bit n. Bit 0 and bits 16 and up always read as 0. The request and acknowledge pins are plain control signals. The acknowledge has no back-pressure: the controller accepts every strobe in the cycle it is presented.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, mask and level registers read 0 and `irq_req` is 0.
- R2: A request line n that is high at a rising clock edge sets pending bit n. The bit is visible on `irq_req` and in the pending register from that edge on.
- R3: A pending bit stays set after its request line falls. Only a software clear or an acknowledge for its number clears it.
- R4: An `ack_valid` strobe with `ack_num` = n clears pending bit n at that edge. Number 0, or any other number, leaves bit n unchanged.
- R5: If a set cause (request line high or force write) for line n is present at the same edge as a clear cause (acknowledge or clear write) for line n, the pending bit ends up set.
- R6: Mask bit n = 1 enables line n. `irq_req` only considers lines that are both pending and enabled, and it is 0 when there are none.
- R7: Level bit n = 1 puts line n in the high level. Any enabled pending high-level line beats every low-level line, and within one level the higher number wins. `irq_req` follows the register state combinationally.
- R8: The level register is at offset 0x00 and the mask register at offset 0x40. Both read back what was written, in bits 15..1. The port always completes in one access phase (`pready` = 1). Unmapped offsets read 0.
- R9: Writing 1s at offset 0x08 sets those pending bits, and writing 1s at offset 0x0C clears them. The pending register at offset 0x04 is read-only, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the offset |
| pready | output | 1 | Always 1 (no wait states) |
| irq_lines | input | 15 | Request lines 15..1, level high |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_num | input | 4 | Number being acknowledged |
| irq_req | output | 4 | Winning enabled pending number, 0 if none |

## Verification
A request line, an acknowledge or a register write takes effect at the first rising edge at which it is presented. `irq_req` shows the result in the same cycle, because no register sits between the pending, mask and level state and the output. The bench drives every stimulus just after a falling edge and samples `irq_req` and `prdata` at the next falling edge, which is one full register stage later. The capture check also samples before that edge, to show that `irq_req` has not yet moved. Read data is taken during the access phase, and the bench never changes a request line while a read is under way.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_LINES = 15;
  localparam int unsigned BUS_AW    = 8;
  localparam int unsigned BUS_DW    = 32;

  localparam logic [7:0] OFS_LEVEL = 8'h00;
  localparam logic [7:0] OFS_PEND  = 8'h04;
  localparam logic [7:0] OFS_FORCE = 8'h08;
  localparam logic [7:0] OFS_CLEAR = 8'h0C;
  localparam logic [7:0] OFS_MASK  = 8'h40;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NLINES = IRQ_LINES,
  parameter int unsigned AW     = BUS_AW,
  parameter int unsigned DW     = BUS_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  input  logic [NLINES:1]   pend_i,
  output logic [NLINES:1]   level_o,
  output logic [NLINES:1]   mask_o,
  output logic [NLINES:1]   force_o,
  output logic [NLINES:1]   swclr_o,
  output logic [DW-1:0]     prdata
);
  localparam int unsigned PAD = DW - NLINES - 1;

  logic              wr_en;
  logic [NLINES:1]   wfield;
  logic [NLINES:1]   rfield;
  logic              unused_wdata;

  assign wr_en        = psel && penable && pwrite;
  assign wfield       = pwdata[NLINES:1];
  assign unused_wdata = ^{pwdata[DW-1:NLINES+1], pwdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= '0;
      mask_o  <= '0;
    end else if (wr_en) begin
      if (paddr == AW'(OFS_LEVEL)) level_o <= wfield;
      if (paddr == AW'(OFS_MASK))  mask_o  <= wfield;
    end
  end

  assign force_o = (wr_en && paddr == AW'(OFS_FORCE)) ? wfield : '0;
  assign swclr_o = (wr_en && paddr == AW'(OFS_CLEAR)) ? wfield : '0;

  always_comb begin
    rfield = '0;
    if (paddr == AW'(OFS_LEVEL)) rfield = level_o;
    if (paddr == AW'(OFS_PEND))  rfield = pend_i;
    if (paddr == AW'(OFS_MASK))  rfield = mask_o;
  end

  assign prdata = {{PAD{1'b0}}, rfield, 1'b0};
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_pkg::*;
#(
  parameter int unsigned NLINES = IRQ_LINES,
  localparam int unsigned NUM_W = $clog2(NLINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINES:1]  irq_i,
  input  logic [NLINES:1]  force_i,
  input  logic [NLINES:1]  swclr_i,
  input  logic             ack_valid_i,
  input  logic [NUM_W-1:0] ack_num_i,
  output logic [NLINES:1]  pend_o
);
  logic [NLINES:1] ack_hit;
  logic [NLINES:1] set_vec;
  logic [NLINES:1] clr_vec;

  for (genvar n = 1; n <= NLINES; n++) begin : g_ack
    assign ack_hit[n] = ack_valid_i && (ack_num_i == NUM_W'(n));
  end

  assign set_vec = irq_i | force_i;
  assign clr_vec = ack_hit | swclr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
#(
  parameter int unsigned NLINES = IRQ_LINES,
  localparam int unsigned NUM_W = $clog2(NLINES + 1)
) (
  input  logic [NLINES:1]  pend_i,
  input  logic [NLINES:1]  mask_i,
  input  logic [NLINES:1]  level_i,
  output logic [NUM_W-1:0] req_o
);
  logic [NLINES:1] hi_set;
  logic [NLINES:1] lo_set;

  function automatic logic [NUM_W-1:0] top_index(input logic [NLINES:1] v);
    logic [NUM_W-1:0] idx;
    idx = '0;
    for (int n = 1; n <= NLINES; n++) begin
      if (v[n]) idx = NUM_W'(n);
    end
    return idx;
  endfunction

  assign hi_set = pend_i & mask_i & level_i;
  assign lo_set = pend_i & mask_i & ~level_i;
  assign req_o  = (|hi_set) ? top_index(hi_set) : top_index(lo_set);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NLINES = IRQ_LINES,
  parameter int unsigned AW     = BUS_AW,
  parameter int unsigned DW     = BUS_DW,
  localparam int unsigned NUM_W = $clog2(NLINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  input  logic [NLINES:1]  irq_lines,
  input  logic             ack_valid,
  input  logic [NUM_W-1:0] ack_num,
  output logic [NUM_W-1:0] irq_req
);
  logic [NLINES:1] pend_q;
  logic [NLINES:1] level_q;
  logic [NLINES:1] mask_q;
  logic [NLINES:1] force_vec;
  logic [NLINES:1] swclr_vec;

  assign pready = 1'b1;

  irq_regs #(.NLINES(NLINES), .AW(AW), .DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pend_i(pend_q),
    .level_o(level_q), .mask_o(mask_q), .force_o(force_vec),
    .swclr_o(swclr_vec), .prdata(prdata)
  );

  irq_pending #(.NLINES(NLINES)) i_pending (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_lines), .force_i(force_vec),
    .swclr_i(swclr_vec), .ack_valid_i(ack_valid), .ack_num_i(ack_num),
    .pend_o(pend_q)
  );

  irq_resolve #(.NLINES(NLINES)) i_resolve (
    .pend_i(pend_q), .mask_i(mask_q), .level_i(level_q), .req_o(irq_req)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int unsigned NLINES = 15,
  localparam int unsigned NUM_W = $clog2(NLINES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NLINES:1]  irq_lines,
  input logic             ack_valid,
  input logic [NUM_W-1:0] ack_num,
  input logic [NUM_W-1:0] irq_req,
  input logic [NLINES:1]  pend_q,
  input logic [NLINES:1]  mask_q,
  input logic [NLINES:1]  level_q,
  input logic [NLINES:1]  force_vec,
  input logic [NLINES:1]  swclr_vec
);
  for (genvar n = 1; n <= NLINES; n++) begin : g_line
    AST_LINE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines[n] || force_vec[n]) |=> pend_q[n]);                          // R2
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[n] && !swclr_vec[n] && !(ack_valid && ack_num == NUM_W'(n)))
      |=> pend_q[n]);                                                          // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_num == NUM_W'(n) && !irq_lines[n] && !force_vec[n])
      |=> !pend_q[n]);                                                         // R4
    AST_WIN_OVER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[n] && mask_q[n] && irq_req != '0) |->
      ((level_q[irq_req] && !level_q[n]) || (level_q[irq_req] == level_q[n]
        && irq_req >= NUM_W'(n))));                                            // R7
  end

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |-> (pend_q[irq_req] && mask_q[irq_req]));                // R6
  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) != '0) |-> (irq_req != '0));                           // R6
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NLINES(NLINES)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ack_valid(ack_valid),
  .ack_num(ack_num), .irq_req(irq_req), .pend_q(pend_q), .mask_q(mask_q),
  .level_q(level_q), .force_vec(force_vec), .swclr_vec(swclr_vec)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  localparam logic [7:0] A_LEVEL = 8'h00;
  localparam logic [7:0] A_PEND  = 8'h04;
  localparam logic [7:0] A_FORCE = 8'h08;
  localparam logic [7:0] A_CLEAR = 8'h0C;
  localparam logic [7:0] A_MASK  = 8'h40;
  localparam logic [31:0] ALL = 32'h0000_FFFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;
  logic [15:1] irq_lines = '0;
  logic ack_valid = 1'b0;
  logic [3:0] ack_num = '0;
  logic [3:0] irq_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irq_lines(irq_lines), .ack_valid(ack_valid), .ack_num(ack_num),
    .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); d = prdata; psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ack(input logic [3:0] num);
    ack_valid = 1'b1; ack_num = num;
    @(negedge clk); ack_valid = 1'b0; ack_num = '0;
  endtask

  function automatic logic [31:0] model(input logic [15:1] p, input logic [15:1] m,
                                        input logic [15:1] l);
    logic [15:1] hi, lo;
    hi = p & m & l; lo = p & m & ~l;
    for (int n = 15; n >= 1; n--) if (hi[n]) return n;
    for (int n = 15; n >= 1; n--) if (lo[n]) return n;
    return 0;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_req", {28'd0, irq_req}, 0);
    bus_read(A_PEND, rd);  check("R1 pending", rd, 0);
    bus_read(A_MASK, rd);  check("R1 mask", rd, 0);
    bus_read(A_LEVEL, rd); check("R1 level", rd, 0);
    check("R8 pready", {31'd0, pready}, 1);

    // R8 read-back, bit 0 and upper bits read 0
    bus_write(A_MASK, 32'hFFFF_FFFF);  bus_read(A_MASK, rd);  check("R8 mask", rd, ALL);
    bus_write(A_LEVEL, 32'h0000_A5A5); bus_read(A_LEVEL, rd); check("R8 level", rd, 32'h0000_A5A4);
    bus_read(8'h10, rd); check("R8 unmapped", rd, 0);
    bus_write(A_LEVEL, 0);

    // R6 masked line not requested
    bus_write(A_MASK, 32'h0000_FFF6);
    bus_write(A_FORCE, 32'h0000_0008);
    check("R6 masked", {28'd0, irq_req}, 0);
    bus_read(A_PEND, rd); check("R9 force sets", rd, 32'h8);
    bus_write(A_MASK, ALL);
    check("R6 enable", {28'd0, irq_req}, 3);
    bus_write(A_CLEAR, ALL);
    bus_read(A_PEND, rd); check("R9 clear", rd, 0);

    // R9 pending read-only
    bus_write(A_PEND, ALL);
    bus_read(A_PEND, rd); check("R9 read-only", rd, 0);

    // R2 capture timing
    irq_lines[9] = 1'b1;
    #1 check("R2 before edge", {28'd0, irq_req}, 0);
    @(negedge clk); irq_lines = '0;
    check("R2 after edge", {28'd0, irq_req}, 9);
    // R3 sticky after fall
    @(negedge clk);
    check("R3 sticky", {28'd0, irq_req}, 9);
    bus_read(A_PEND, rd); check("R3 pending", rd, 32'h200);
    // R4 ack 0 and other number no effect, matching number clears
    ack(4'd0); check("R4 ack zero", {28'd0, irq_req}, 9);
    ack(4'd8); check("R4 other num", {28'd0, irq_req}, 9);
    ack(4'd9); check("R4 ack clears", {28'd0, irq_req}, 0);
    bus_read(A_PEND, rd); check("R4 pending", rd, 0);

    // R5 request with ack at the same edge
    bus_write(A_FORCE, 32'h80);
    irq_lines[7] = 1'b1; ack_valid = 1'b1; ack_num = 4'd7;
    @(negedge clk); irq_lines = '0; ack_valid = 1'b0;
    check("R5 ack vs request", {28'd0, irq_req}, 7);
    ack(4'd7); check("R4 ack plain", {28'd0, irq_req}, 0);
    // R5 request with clear write at the same edge
    irq_lines[2] = 1'b1;
    bus_write(A_CLEAR, 32'h4);
    irq_lines = '0;
    @(negedge clk);
    check("R5 clear vs request", {28'd0, irq_req}, 2);
    bus_write(A_CLEAR, ALL);

    // R7 walking level bit over all lines pending
    for (int n = 1; n <= 15; n++) begin
      bus_write(A_LEVEL, 32'(1) << n);
      bus_write(A_FORCE, ALL);
      check("R7 walking level", {28'd0, irq_req}, n);
    end
    bus_write(A_LEVEL, 0);
    check("R7 all low", {28'd0, irq_req}, 15);

    // R6 R7 arithmetic sweep
    for (int i = 0; i < 400; i++) begin
      logic [15:1] p, m, l;
      p = 15'((i * 40503) ^ (i << 5));
      m = 15'((i * 27459) + i * 7 + 3);
      l = 15'((i * 49841) >> 2);
      if (i % 4 == 0) m = '1;
      bus_write(A_CLEAR, ALL);
      bus_write(A_MASK, {16'd0, m, 1'b0});
      bus_write(A_LEVEL, {16'd0, l, 1'b0});
      bus_write(A_FORCE, {16'd0, p, 1'b0});
      check("R7 sweep", {28'd0, irq_req}, model(p, m, l));
      if (i % 16 == 0) begin
        bus_read(A_PEND, rd); check("R9 sweep pending", rd, {16'd0, p, 1'b0});
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule